// File: doc/BRIEF.md
# PCI Target Termination Controller

This block sits beside the data path of a PCI-style bus target. It decides when the target ends a transaction early and how it does so. In the address phase it captures the command and the low address bits. After that it counts completed data phases, measures the idle clocks between them and follows the streaming word address. Three kinds of early end come out of this. A retry is issued when the target is busy. A target abort is issued on an error. A disconnect is issued, with or without data, when one of six conditions is met: a configuration access, a reserved burst ordering, reaching the last word of a 4 KB page, the last word of a cache-line wrap, no free entry in the local I/O sequencer, or too many idle clocks between data phases.

Every bus signal at the ports is active high. Any inversion to the bus pin polarity is done outside the block. The bus responses DEVSEL, TRDY and STOP are derived from registered state, so none of them depends combinationally on a bus input. The block also watches the initiator's request line for two clocks after every STOP termination. If the initiator requests the bus again too soon, the block raises a one-cycle flag.

Top module: `pci_term_ctrl`

## Requirements
- R1: After reset, and whenever reset is asserted during a transaction, devsel, trdy, stop and reqViol are all 0.
- R2: If busy is high on the clock edge that samples frame rising from idle, the next cycle shows devsel=1, stop=1 and trdy=0, so no data moves.
- R3: If error is high in the address phase or in any transfer cycle, the next cycle shows stop=1, devsel=0 and trdy=0.
- R4: For a configuration command (cmd 4'b1010 or 4'b1011), the first data phase shows stop and trdy together. Once that phase completes (irdy and trdy both sampled high), stop stays high with trdy=0.
- R5: If addrLow[0]=1 in the address phase (reserved burst ordering), the behaviour is the same as R4: only one data phase, carried with stop.
- R6: In linear order (addrLow[1:0]=2'b00), the word address advances by one on each completed phase. The phase whose word address is the last one of the 4 KB page (addrLow[11:2] all ones) shows stop with trdy. After it completes, trdy drops while stop stays high.
- R7: In cache-line wrap order (addrLow[1:0]=2'b10), the word address wraps inside a LINE_WORDS-word line. The LINE_WORDS-th data phase shows stop with trdy, and the page rule of R6 does not apply.
- R8: If bufAvail is sampled low during a transfer while frame is high, the next cycle shows stop=1 and trdy=0.
- R9: If LAT_LIMIT (8) consecutive clock edges in a transfer pass with no completed phase, the next cycle shows stop=1 and trdy=0. Every completed phase restarts the count.
- R10: Once stop is high, it stays high while frame is sampled high. On the clock after frame is sampled low at the end of the transfer, devsel, trdy and stop all go to 0.
- R11: On each of the two clock edges that follow the edge ending a STOP termination, initReq sampled high sets reqViol for one cycle. Outside that window, reqViol stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frame | input | 1 | Initiator frame, high while the transaction runs |
| irdy | input | 1 | Initiator ready |
| cmd | input | 4 | Bus command, sampled in the address phase |
| addrLow | input | OFS_W | Low address bits: [1:0] burst ordering, [OFS_W-1:2] word within page |
| busy | input | 1 | Target cannot service the request now (retry) |
| error | input | 1 | Fatal target error (abort) |
| bufAvail | input | 1 | I/O sequencer has a free buffer entry |
| initReq | input | 1 | Initiator bus request, high when requesting |
| devsel | output | 1 | Device select response |
| trdy | output | 1 | Target ready |
| stop | output | 1 | Stop request to the initiator |
| reqViol | output | 1 | One-cycle flag: request reasserted inside the two-clock hold window |

## Verification
The assertions assume that the initiator follows the bus protocol. That means frame is held high until the final phase, frame drops only in a cycle with irdy high or after stop, and a new address phase starts only from idle. Under this assumption, a stop that carries trdy always ends in a completed phase. The stimulus keeps to these rules: in every table sequence, frame drops together with irdy or while a stop without data is showing, and the next address phase follows only after the release cycle. Errors and busy are raised only in the address phase or in a transfer cycle, never while a termination is already showing.

// File: rtl/term_pkg.sv
package term_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_DISC,
    ST_RETRY,
    ST_ABORT
  } termState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;   // address phase accepted
    logic advance;   // data phase completed
    logic tick;      // transfer cycle without completion
    logic termEnd;   // STOP termination finished this edge
  } dpStrobe_t;

endpackage

// File: rtl/term_dp.sv
module term_dp
  import term_pkg::*;
#(
  parameter int OFS_W      = 12,
  parameter int LAT_LIMIT  = 8,
  parameter int LINE_WORDS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [3:0]       cmd,
  input  logic [OFS_W-1:0] addrLow,
  input  logic             initReq,
  output logic             lastNow,
  output logic             latExpired,
  output logic             reqViol
);

  localparam int WORD_W = OFS_W - 2;
  localparam int LAT_W  = $clog2(LAT_LIMIT + 1);
  localparam int PH_W   = $clog2(LINE_WORDS) + 1;
  localparam logic [WORD_W-1:0] LINE_MASK = WORD_W'(LINE_WORDS - 1);

  logic [WORD_W-1:0] wordQ;
  logic [PH_W-1:0]   phaseQ;
  logic [LAT_W-1:0]  latQ;
  logic              cfgQ, rsvdQ, linQ, wrapQ;
  logic [1:0]        holdQ;
  logic [WORD_W-1:0] wordInc, wordNext;
  logic              pageLast, lineLast;

  assign wordInc  = wordQ + 1'b1;
  assign wordNext = wrapQ ? ((wordQ & ~LINE_MASK) | (wordInc & LINE_MASK)) : wordInc;
  assign pageLast = &wordQ;
  assign lineLast = (phaseQ == PH_W'(LINE_WORDS - 1));

  assign lastNow    = cfgQ | rsvdQ | (linQ & pageLast) | (wrapQ & lineLast);
  assign latExpired = (latQ == LAT_W'(LAT_LIMIT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ  <= '0;
      phaseQ <= '0;
      latQ   <= '0;
      cfgQ   <= 1'b0;
      rsvdQ  <= 1'b0;
      linQ   <= 1'b0;
      wrapQ  <= 1'b0;
    end else if (stb.capture) begin
      wordQ  <= addrLow[OFS_W-1:2];
      phaseQ <= '0;
      latQ   <= '0;
      cfgQ   <= (cmd == 4'b1010) || (cmd == 4'b1011);
      rsvdQ  <= addrLow[0];
      linQ   <= (addrLow[1:0] == 2'b00);
      wrapQ  <= (addrLow[1:0] == 2'b10);
    end else if (stb.advance) begin
      wordQ  <= wordNext;
      phaseQ <= phaseQ + 1'b1;
      latQ   <= '0;
    end else if (stb.tick && (latQ != LAT_W'(LAT_LIMIT))) begin
      latQ   <= latQ + 1'b1;
    end
  end

  // request hold window after a STOP termination
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ   <= '0;
      reqViol <= 1'b0;
    end else begin
      reqViol <= (holdQ != 2'd0) && initReq;
      if (stb.termEnd)        holdQ <= 2'd2;
      else if (holdQ != 2'd0) holdQ <= holdQ - 1'b1;
    end
  end

  // R11
  req_flag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqViol |-> $past(initReq));

  // R9
  lat_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> !latExpired);

endmodule

// File: rtl/term_fsm.sv
module term_fsm
  import term_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frame,
  input  logic      irdy,
  input  logic      busy,
  input  logic      error,
  input  logic      bufAvail,
  input  logic      lastNow,
  input  logic      latExpired,
  output dpStrobe_t stb,
  output logic      devsel,
  output logic      trdy,
  output logic      stop
);

  termState_t state, nxt;
  logic       done;

  assign done = irdy && (state == ST_XFER);

  always_comb begin
    nxt = state;
    stb = '0;
    case (state)
      ST_IDLE: begin
        if (frame) begin
          stb.capture = 1'b1;
          if (error)     nxt = ST_ABORT;
          else if (busy) nxt = ST_RETRY;
          else           nxt = ST_XFER;
        end
      end
      ST_XFER: begin
        stb.advance = done;
        stb.tick    = !done;
        if (error) nxt = ST_ABORT;
        else if (done && !frame) begin
          nxt         = ST_IDLE;
          stb.termEnd = lastNow;
        end
        else if (done && lastNow)       nxt = ST_DISC;
        else if (!bufAvail)             nxt = ST_DISC;
        else if (!done && latExpired)   nxt = ST_DISC;
      end
      ST_DISC, ST_RETRY, ST_ABORT: begin
        if (!frame) begin
          nxt         = ST_IDLE;
          stb.termEnd = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign devsel = (state == ST_XFER) || (state == ST_DISC) || (state == ST_RETRY);
  assign trdy   = (state == ST_XFER);
  assign stop   = (state == ST_DISC) || (state == ST_RETRY) || (state == ST_ABORT) ||
                  ((state == ST_XFER) && lastNow);

  // R9
  lat_disc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XFER && !irdy && latExpired) |=> (stop && !trdy));

  // R8
  buf_disc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XFER && !bufAvail && frame) |=> (stop && !trdy));

  // R2
  retry_nodata_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && frame && busy && !error) |=> (stop && devsel && !trdy));

endmodule

// File: rtl/pci_term_ctrl.sv
module pci_term_ctrl
  import term_pkg::*;
#(
  parameter int OFS_W      = 12,
  parameter int LAT_LIMIT  = 8,
  parameter int LINE_WORDS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frame,
  input  logic             irdy,
  input  logic [3:0]       cmd,
  input  logic [OFS_W-1:0] addrLow,
  input  logic             busy,
  input  logic             error,
  input  logic             bufAvail,
  input  logic             initReq,
  output logic             devsel,
  output logic             trdy,
  output logic             stop,
  output logic             reqViol
);

  dpStrobe_t stb;
  logic      lastNow, latExpired;

  term_fsm u_fsm (
    .clk(clk), .rstN(rstN), .frame(frame), .irdy(irdy), .busy(busy),
    .error(error), .bufAvail(bufAvail), .lastNow(lastNow),
    .latExpired(latExpired), .stb(stb), .devsel(devsel), .trdy(trdy), .stop(stop)
  );

  term_dp #(.OFS_W(OFS_W), .LAT_LIMIT(LAT_LIMIT), .LINE_WORDS(LINE_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmd(cmd), .addrLow(addrLow),
    .initReq(initReq), .lastNow(lastNow), .latExpired(latExpired), .reqViol(reqViol)
  );

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stop && frame) |=> stop);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stop && !frame && !error && (!trdy || irdy)) |=> (!stop && !trdy && !devsel));

  // R3
  abort_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stop && !devsel) |-> !trdy);

  // R4
  cfg_first_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stop && !devsel && frame && !busy && !error &&
     ((cmd == 4'b1010) || (cmd == 4'b1011))) |=> (stop && trdy));

endmodule

// File: tb/pci_term_ctrl_test.sv
`timescale 1ns/1ps
module pci_term_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frame = 1'b0, irdy = 1'b0, busy = 1'b0, error = 1'b0;
  logic        bufAvail = 1'b1, initReq = 1'b0;
  logic [3:0]  cmd = 4'h0;
  logic [11:0] addrLow = 12'h000;
  logic        devsel, trdy, stop, reqViol;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pci_term_ctrl uut (
    .clk(clk), .rstN(rstN), .frame(frame), .irdy(irdy), .cmd(cmd),
    .addrLow(addrLow), .busy(busy), .error(error), .bufAvail(bufAvail),
    .initReq(initReq), .devsel(devsel), .trdy(trdy), .stop(stop), .reqViol(reqViol)
  );

  // row: tag[29:26] | frame,irdy,busy,error,bufAvail,initReq [25:20] | cmd [19:16]
  //      | addrLow [15:4] | expected devsel,trdy,stop,reqViol [3:0]
  localparam int NROWS = 47;
  localparam logic [29:0] VEC [NROWS] = '{
    // R4 configuration access
    {4'd4,  6'b100010, 4'hA, 12'h000, 4'b1110},
    {4'd4,  6'b110010, 4'hA, 12'h000, 4'b1010},
    {4'd10, 6'b010010, 4'hA, 12'h000, 4'b0000},
    // R2 retry, then R11 hold window
    {4'd2,  6'b101010, 4'h6, 12'h000, 4'b1010},
    {4'd10, 6'b100010, 4'h6, 12'h000, 4'b1010},
    {4'd10, 6'b000010, 4'h6, 12'h000, 4'b0000},
    {4'd11, 6'b000011, 4'h6, 12'h000, 4'b0001},
    {4'd11, 6'b000010, 4'h6, 12'h000, 4'b0000},
    {4'd11, 6'b000011, 4'h6, 12'h000, 4'b0000},
    // R3 abort in address phase
    {4'd3,  6'b100110, 4'h6, 12'h000, 4'b0010},
    {4'd10, 6'b000010, 4'h6, 12'h000, 4'b0000},
    // R9 latency: 5 idle, one phase, then 8 idle
    {4'd9,  6'b100010, 4'h6, 12'h100, 4'b1100},
    {4'd9,  6'b100010, 4'h6, 12'h100, 4'b1100},
    {4'd9,  6'b100010, 4'h6, 12'h100, 4'b1100},
    {4'd9,  6'b100010, 4'h6, 12'h100, 4'b1100},
    {4'd9,  6'b100010, 4'h6, 12'h100, 4'b1100},
    {4'd9,  6'b100010, 4'h6, 12'h100, 4'b1100},
    {4'd9,  6'b110010, 4'h6, 12'h100, 4'b1100},
    {4'd9,  6'b100010, 4'h6, 12'h100, 4'b1100},
    {4'd9,  6'b100010, 4'h6, 12'h100, 4'b1100},
    {4'd9,  6'b100010, 4'h6, 12'h100, 4'b1100},
    {4'd9,  6'b100010, 4'h6, 12'h100, 4'b1100},
    {4'd9,  6'b100010, 4'h6, 12'h100, 4'b1100},
    {4'd9,  6'b100010, 4'h6, 12'h100, 4'b1100},
    {4'd9,  6'b100010, 4'h6, 12'h100, 4'b1100},
    {4'd9,  6'b100010, 4'h6, 12'h100, 4'b1010},
    {4'd10, 6'b000010, 4'h6, 12'h100, 4'b0000},
    // R6 page boundary
    {4'd6,  6'b100010, 4'h6, 12'hFF8, 4'b1100},
    {4'd6,  6'b110010, 4'h6, 12'hFF8, 4'b1110},
    {4'd6,  6'b110010, 4'h6, 12'hFF8, 4'b1010},
    {4'd10, 6'b010010, 4'h6, 12'hFF8, 4'b0000},
    // R8 buffer exhausted
    {4'd8,  6'b100010, 4'h6, 12'h000, 4'b1100},
    {4'd8,  6'b110000, 4'h6, 12'h000, 4'b1010},
    {4'd10, 6'b000010, 4'h6, 12'h000, 4'b0000},
    // R7 cache-line wrap across the page end
    {4'd7,  6'b100010, 4'h6, 12'hFF2, 4'b1100},
    {4'd7,  6'b110010, 4'h6, 12'hFF2, 4'b1100},
    {4'd7,  6'b110010, 4'h6, 12'hFF2, 4'b1100},
    {4'd7,  6'b110010, 4'h6, 12'hFF2, 4'b1100},
    {4'd7,  6'b110010, 4'h6, 12'hFF2, 4'b1100},
    {4'd7,  6'b110010, 4'h6, 12'hFF2, 4'b1100},
    {4'd7,  6'b110010, 4'h6, 12'hFF2, 4'b1100},
    {4'd7,  6'b110010, 4'h6, 12'hFF2, 4'b1110},
    {4'd7,  6'b110010, 4'h6, 12'hFF2, 4'b1010},
    {4'd10, 6'b010010, 4'h6, 12'hFF2, 4'b0000},
    // R5 reserved burst ordering
    {4'd5,  6'b100010, 4'h6, 12'h101, 4'b1110},
    {4'd5,  6'b110010, 4'h6, 12'h101, 4'b1010},
    {4'd10, 6'b000010, 4'h6, 12'h101, 4'b0000}
  };

  task automatic checkOut(input int tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {devsel, trdy, stop, reqViol};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: outputs {devsel,trdy,stop,reqViol} actual=%b expected=%b",
               tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] ctl, input logic [3:0] c, input logic [11:0] a);
    {frame, irdy, busy, error, bufAvail, initReq} = ctl;
    cmd = c;
    addrLow = a;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checkOut(1, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    checkOut(1, 4'b0000);

    for (int i = 0; i < NROWS; i++) begin
      drive(VEC[i][25:20], VEC[i][19:16], VEC[i][15:4]);
      @(negedge clk);
      checkOut(int'(VEC[i][29:26]), VEC[i][3:0]);
    end

    // R3 abort during a transfer cycle
    drive(6'b100010, 4'h7, 12'h200);
    @(negedge clk);
    checkOut(3, 4'b1100);
    drive(6'b100110, 4'h7, 12'h200);
    @(negedge clk);
    checkOut(3, 4'b0010);
    drive(6'b000010, 4'h7, 12'h200);
    @(negedge clk);
    checkOut(10, 4'b0000);

    // R1 reset in the middle of a transfer
    drive(6'b100010, 4'h6, 12'h040);
    @(negedge clk);
    checkOut(1, 4'b1100);
    rstN = 1'b0;
    #1;
    checkOut(1, 4'b0000);
    drive(6'b000010, 4'h6, 12'h040);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut(1, 4'b0000);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule